// File: doc/BRIEF.md
# Five-Channel Timer Compare, Capture and PWM Unit

The unit has one free-running 16-bit counter that several channels share. Two control bits pick what advances the counter. The choices are the system clock divided by 12, the system clock divided by 4, a one-cycle overflow pulse from a neighbouring timer, or the rising edge of an external pin. Each channel has a 16-bit value register, a mode register, an input pin, an output pin and a sticky event flag.

Each channel can work in one of four ways. It can latch the counter on a chosen edge of its input pin. It can raise its flag when the counter reaches its value, and optionally toggle its output pin at that point. It can produce an 8-bit pulse-width signal from the counter's low byte. The duty byte of that signal is taken from a shadow byte at every low-byte rollover, so a new duty value never takes effect in the middle of a period. The last channel can instead act as a watchdog that issues a reset pulse on a match.

Software controls the unit through a byte-wide write port. It reads the unit's state from the output ports. The interrupt request is the OR of the event flags that are enabled.

Top module: `cap_cmp_array`

Write address map (5-bit address):
- 0x00: control. Bit 0 is run. Bits 2:1 are the clock source (0 = /12, 1 = /4, 2 = timer pulse, 3 = external pin). Bit 3 is the overflow interrupt enable. Bit 4 is the watchdog enable.
- 0x01: flag clear. Writing a 1 clears the matching flag. Bits n clear channel n; bit 7 clears the overflow flag.
- 0x02 and 0x03: counter low byte and counter high byte.
- 0x08+n: mode of channel n. Bit 0 is the interrupt enable, bit 1 PWM, bit 2 toggle, bit 3 match, bit 4 falling-edge capture, bit 5 rising-edge capture, bit 6 comparator enable.
- 0x10+n and 0x18+n: low byte and high byte of the value register of channel n.

## Requirements
- R1: After reset the counter, all value registers, all modes, all flags, the output pins, the interrupt request, the comparator enables and the watchdog pulse are all zero.
- R2: While control bit 0 is set, the counter advances once every 12 clocks with source 0 and once every 4 clocks with source 1. With source 2 it advances once per clock in which timer_ovf_i is high. With source 3 it advances once per synchronized rising edge of ext_clk_i. While control bit 0 is clear, the counter holds.
- R3: A counter step from 0xFFFF to 0x0000 sets the overflow flag. When control bit 3 is set, that flag drives irq_o.
- R4: When mode bit 5 is set, a rising edge on a channel's input pin copies the counter into its value register and sets its flag. Mode bit 4 does the same for a falling edge. An edge whose capture bit is clear changes neither the value nor the flag.
- R5: When mode bits 6 and 3 are set and a counter step reaches the channel value, the channel flag is set in that same step. If mode bit 2 is also set, the output pin toggles.
- R6: In PWM mode the output pin is 1 when the counter low byte is greater than or equal to the value low byte, and 0 when it is smaller. The pin follows the counter one clock later.
- R7: In PWM mode, a counter step that takes the low byte from 0xFF to 0x00 copies the value high byte into the value low byte.
- R8: PWM output needs both mode bit 1 and mode bit 6. When only bit 1 is set, the output pin holds.
- R9: When control bit 4 is set, a match on the last channel produces a one-clock pulse on wdog_rst_o, and that channel's pin does not toggle. It still sets the channel flag.
- R10: A write to a channel's value low byte clears its mode bit 6. A write to its high byte sets that bit again.
- R11: Flags stay set until a 1 is written to their bit at 0x01. If a flag is set and cleared in the same clock, the set wins. irq_o is the OR of each channel flag ANDed with its mode bit 0, together with the enabled overflow flag.
- R12: Writes to 0x02 and 0x03 load the counter's low byte and high byte, and a load takes priority over a counter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| timer_ovf_i | input | 1 | Overflow pulse from a neighbouring timer |
| ext_clk_i | input | 1 | External count pin (asynchronous) |
| cap_pin_i | input | NCH | Channel input pins (asynchronous) |
| cmp_pin_o | output | NCH | Channel output pins |
| count_o | output | 16 | Counter value |
| value_o | output | NCH*16 | Channel value registers, channel n at bits 16n+15:16n |
| flags_o | output | NCH | Channel event flags |
| ovf_flag_o | output | 1 | Counter overflow flag |
| cmp_en_o | output | NCH | Comparator enable (mode bit 6) of each channel |
| irq_o | output | 1 | Interrupt request |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
A counter step, a match flag, a pin toggle, a watchdog pulse and a PWM reload all take effect at the clock edge that makes the step, so the bench checks them at the falling edge that follows the timer pulse. The PWM pin is registered and lags the counter by one clock, and a capture lands three edges after an input pin changes because of the two-flop synchronizer and the edge register. The bench therefore waits two clocks for PWM checks and four clocks for capture checks before it samples. The divider tests stop the counter at an exact edge count after run is set, so the expected count is a whole number of periods.

// File: rtl/cca_pkg.sv
// Package: shared constants for the compare/capture/PWM unit.
// Assumes a 5-bit write address, byte-wide write data and at most 7 channels.
package cca_pkg;
    localparam int ADDR_W = 5;

    // Clock source codes held in control bits 2:1
    typedef enum logic [1:0] {
        SRC_DIV12 = 2'd0,
        SRC_DIV4  = 2'd1,
        SRC_TMR   = 2'd2,
        SRC_PIN   = 2'd3
    } clk_src_e;

    // Control register bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_SRC  = 1;
    localparam int CB_OVIE = 3;
    localparam int CB_WDOG = 4;
    localparam int CTRL_W  = 5;

    // Channel mode bit positions
    localparam int MB_IE   = 0;
    localparam int MB_PWM  = 1;
    localparam int MB_TOG  = 2;
    localparam int MB_MAT  = 3;
    localparam int MB_CAPN = 4;
    localparam int MB_CAPP = 5;
    localparam int MB_ECOM = 6;
    localparam int MODE_W  = 7;

    // Fixed addresses (region 00) and channel regions on addr[4:3]
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_CLR  = 5'h01;
    localparam logic [ADDR_W-1:0] A_CNTL = 5'h02;
    localparam logic [ADDR_W-1:0] A_CNTH = 5'h03;
    localparam logic [1:0] RG_MODE = 2'b01;
    localparam logic [1:0] RG_VLO  = 2'b10;
    localparam logic [1:0] RG_VHI  = 2'b11;
endpackage

// File: rtl/cca_timebase.sv
// Module: cca_timebase
// Shared counter with its prescaler and clock-source selection.
// Assumes the external pin toggles no faster than one edge per 4 clocks,
// and that a byte load in the same clock as a step takes priority.
module cca_timebase
    import cca_pkg::*;
#(
    parameter int CW       = 16,
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  clk_src_e        src,
    input  logic            tmr_pulse,
    input  logic            ext_pin,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic [CW/2-1:0] ld_data,
    output logic [CW-1:0]   cnt,
    output logic [CW-1:0]   cnt_nxt,
    output logic            step,
    output logic            lo_wrap,
    output logic            ovf
);
    localparam int HB = CW / 2;
    localparam int PW = $clog2(DIV_SLOW);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] pre_last;
    logic          e_s1, e_s2, e_s3;
    logic          ext_rise;
    logic          tick_raw;
    logic [CW-1:0] cnt_q;

    assign pre_last = (src == SRC_DIV4) ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);

    // Prescaler: counts through one divider period while running
    always_ff @(posedge clk) begin
        if (!rst_n || !run || pre_q == pre_last) pre_q <= '0;
        else                                     pre_q <= pre_q + 1'b1;
    end

    // External pin synchronizer and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_s1 <= 1'b0; e_s2 <= 1'b0; e_s3 <= 1'b0;
        end else begin
            e_s1 <= ext_pin; e_s2 <= e_s1; e_s3 <= e_s2;
        end
    end
    assign ext_rise = e_s2 & ~e_s3;

    // Source selection for one counter step
    always_comb begin
        unique case (src)
            SRC_DIV12, SRC_DIV4: tick_raw = (pre_q == pre_last);
            SRC_TMR:             tick_raw = tmr_pulse;
            default:             tick_raw = ext_rise;
        endcase
    end

    assign step    = run & tick_raw & ~ld_lo & ~ld_hi;
    assign cnt_nxt = cnt_q + CW'(1);
    assign lo_wrap = step & (&cnt_q[HB-1:0]);
    assign ovf     = step & (&cnt_q);
    assign cnt     = cnt_q;

    // Counter: byte loads first, then steps
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (ld_lo) cnt_q[HB-1:0] <= ld_data;
        else if (ld_hi) cnt_q[CW-1:HB] <= ld_data;
        else if (step)  cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/cca_channel.sv
// Module: cca_channel
// One channel: capture, compare/toggle, 8-bit PWM with shadow reload,
// and an optional watchdog role. Assumes a step is the only moment the
// counter advances; matches are taken against the value being stepped to.
module cca_channel
    import cca_pkg::*;
#(
    parameter int CW       = 16,
    parameter bit WDOG_CAP = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   cnt,
    input  logic [CW-1:0]   cnt_nxt,
    input  logic            step,
    input  logic            lo_wrap,
    input  logic            wdog_en,
    input  logic            mode_wr,
    input  logic            lo_wr,
    input  logic            hi_wr,
    input  logic [CW/2-1:0] wdata,
    input  logic            pin_i,
    input  logic            flag_clr,
    output logic [CW-1:0]   val,
    output logic            flag,
    output logic            pin_o,
    output logic            int_en,
    output logic            cmp_en,
    output logic            wdog_hit
);
    localparam int HB = CW / 2;

    logic [MODE_W-1:0] mode_q;
    logic [CW-1:0]     val_q;
    logic              p_s1, p_s2, p_s3;
    logic              cap_ev, match_ev, pwm_on, wd_mode;
    logic              flag_q, pin_q, hit_q;

    assign pwm_on   = mode_q[MB_PWM] & mode_q[MB_ECOM];
    assign wd_mode  = WDOG_CAP & wdog_en;
    assign match_ev = step & mode_q[MB_ECOM] & mode_q[MB_MAT] & (cnt_nxt == val_q);
    assign cap_ev   = (mode_q[MB_CAPP] & p_s2 & ~p_s3) | (mode_q[MB_CAPN] & ~p_s2 & p_s3);

    // Input pin synchronizer and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_s1 <= 1'b0; p_s2 <= 1'b0; p_s3 <= 1'b0;
        end else begin
            p_s1 <= pin_i; p_s2 <= p_s1; p_s3 <= p_s2;
        end
    end

    // Mode register; value byte writes drive the comparator enable
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= wdata[MODE_W-1:0];
        else if (lo_wr)   mode_q[MB_ECOM] <= 1'b0;
        else if (hi_wr)   mode_q[MB_ECOM] <= 1'b1;
    end

    // Value register: software write, then capture, then PWM reload
    always_ff @(posedge clk) begin
        if (!rst_n)                val_q <= '0;
        else if (lo_wr)            val_q[HB-1:0] <= wdata;
        else if (hi_wr)            val_q[CW-1:HB] <= wdata;
        else if (cap_ev)           val_q <= cnt;
        else if (pwm_on & lo_wrap) val_q[HB-1:0] <= val_q[CW-1:HB];
    end

    // Sticky event flag, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (match_ev || cap_ev) flag_q <= 1'b1;
        else if (flag_clr)           flag_q <= 1'b0;
    end

    // Output pin: PWM compare or match toggle
    always_ff @(posedge clk) begin
        if (!rst_n)      pin_q <= 1'b0;
        else if (pwm_on) pin_q <= (cnt[HB-1:0] >= val_q[HB-1:0]);
        else if (match_ev && mode_q[MB_TOG] && !wd_mode) pin_q <= ~pin_q;
    end

    // Watchdog pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= match_ev & wd_mode;
    end

    assign val      = val_q;
    assign flag     = flag_q;
    assign pin_o    = pin_q;
    assign int_en   = mode_q[MB_IE];
    assign cmp_en   = mode_q[MB_ECOM];
    assign wdog_hit = hit_q;
endmodule

// File: rtl/cap_cmp_array.sv
// Module: cap_cmp_array
// Top level: write decode, control register, overflow flag, interrupt
// combine and the channel array. Assumes NCH <= 7 so a clear bit fits
// below bit 7 of the write data, and that the last channel is the watchdog.
module cap_cmp_array
    import cca_pkg::*;
#(
    parameter int NCH      = 5,
    parameter int CW       = 16,
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW/2-1:0]   wr_data,
    input  logic              timer_ovf_i,
    input  logic              ext_clk_i,
    input  logic [NCH-1:0]    cap_pin_i,
    output logic [NCH-1:0]    cmp_pin_o,
    output logic [CW-1:0]     count_o,
    output logic [NCH*CW-1:0] value_o,
    output logic [NCH-1:0]    flags_o,
    output logic              ovf_flag_o,
    output logic [NCH-1:0]    cmp_en_o,
    output logic              irq_o,
    output logic              wdog_rst_o
);
    localparam int HB = CW / 2;

    logic [CTRL_W-1:0] ctrl_q;
    logic              ovf_q;
    logic              wr_ctrl, wr_clr, ld_lo, ld_hi;
    logic [CW-1:0]     cnt, cnt_nxt;
    logic              step, lo_wrap, ovf;
    logic [NCH-1:0]    ie_v, hit_v;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_clr  = wr_en && (wr_addr == A_CLR);
    assign ld_lo   = wr_en && (wr_addr == A_CNTL);
    assign ld_hi   = wr_en && (wr_addr == A_CNTH);

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
    end

    // Sticky overflow flag, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)                        ovf_q <= 1'b0;
        else if (ovf)                      ovf_q <= 1'b1;
        else if (wr_clr && wr_data[HB-1])  ovf_q <= 1'b0;
    end

    cca_timebase #(.CW(CW), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q[CB_RUN]),
        .src      (clk_src_e'(ctrl_q[CB_SRC+1:CB_SRC])),
        .tmr_pulse(timer_ovf_i),
        .ext_pin  (ext_clk_i),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .ld_data  (wr_data),
        .cnt      (cnt),
        .cnt_nxt  (cnt_nxt),
        .step     (step),
        .lo_wrap  (lo_wrap),
        .ovf      (ovf)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [2:0] IDX = 3'(i);
        logic hit_idx;
        assign hit_idx = (wr_addr[2:0] == IDX);

        cca_channel #(.CW(CW), .WDOG_CAP(i == NCH - 1)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .cnt_nxt (cnt_nxt),
            .step    (step),
            .lo_wrap (lo_wrap),
            .wdog_en (ctrl_q[CB_WDOG]),
            .mode_wr (wr_en && wr_addr[4:3] == RG_MODE && hit_idx),
            .lo_wr   (wr_en && wr_addr[4:3] == RG_VLO && hit_idx),
            .hi_wr   (wr_en && wr_addr[4:3] == RG_VHI && hit_idx),
            .wdata   (wr_data),
            .pin_i   (cap_pin_i[i]),
            .flag_clr(wr_clr && wr_data[i]),
            .val     (value_o[i*CW +: CW]),
            .flag    (flags_o[i]),
            .pin_o   (cmp_pin_o[i]),
            .int_en  (ie_v[i]),
            .cmp_en  (cmp_en_o[i]),
            .wdog_hit(hit_v[i])
        );
    end

    assign count_o    = cnt;
    assign ovf_flag_o = ovf_q;
    assign irq_o      = (|(flags_o & ie_v)) | (ovf_q & ctrl_q[CB_OVIE]);
    assign wdog_rst_o = |hit_v;
endmodule

// File: rtl/cca_checker.sv
// Module: cca_checker
// Port-level properties of cap_cmp_array, bound to every instance.
// Assumes the package address map; observes only top-level ports.
module cca_checker
    import cca_pkg::*;
#(
    parameter int NCH = 5,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NCH-1:0]    clr_bits,
    input logic [CW-1:0]     count_o,
    input logic [NCH-1:0]    flags_o,
    input logic              ovf_flag_o,
    input logic [NCH-1:0]    cmp_en_o,
    input logic              irq_o,
    input logic              wdog_rst_o
);
    logic [NCH-1:0] clr_mask, lo_sel, hi_sel;

    // Decode of the write port as seen from outside
    always_comb begin
        clr_mask = (wr_en && wr_addr == A_CLR) ? clr_bits : '0;
        for (int i = 0; i < NCH; i++) begin
            lo_sel[i] = wr_en && wr_addr[4:3] == RG_VLO && wr_addr[2:0] == 3'(i);
            hi_sel[i] = wr_en && wr_addr[4:3] == RG_VHI && wr_addr[2:0] == 3'(i);
        end
    end

    a_r3_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $past(count_o) == '1 && count_o == '0) |-> ovf_flag_o);

    a_r9_wdog_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |=> !wdog_rst_o);

    a_r11_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_o != '0 || ovf_flag_o));

    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags_o) & ~$past(clr_mask) & ~flags_o) == '0));

    a_r10_lo_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|lo_sel) |=> ((cmp_en_o & $past(lo_sel)) == '0));

    a_r10_hi_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|hi_sel) |=> ((cmp_en_o & $past(hi_sel)) == $past(hi_sel)));
endmodule

bind cap_cmp_array cca_checker #(.NCH(NCH), .CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .clr_bits  (wr_data[NCH-1:0]),
    .count_o   (count_o),
    .flags_o   (flags_o),
    .ovf_flag_o(ovf_flag_o),
    .cmp_en_o  (cmp_en_o),
    .irq_o     (irq_o),
    .wdog_rst_o(wdog_rst_o)
);

// File: tb/cap_cmp_array_tb.sv
// Bench for cap_cmp_array: a PWM vector table walked by one loop, then
// directed tests. Inputs change at falling edges, outputs are read there.
module cap_cmp_array_tb_top;
    localparam int NCH = 5;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              timer_ovf_i = 1'b0;
    logic              ext_clk_i = 1'b0;
    logic [NCH-1:0]    cap_pin_i = '0;
    logic [NCH-1:0]    cmp_pin_o;
    logic [CW-1:0]     count_o;
    logic [NCH*CW-1:0] value_o;
    logic [NCH-1:0]    flags_o;
    logic              ovf_flag_o;
    logic [NCH-1:0]    cmp_en_o;
    logic              irq_o;
    logic              wdog_rst_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cap_cmp_array #(.NCH(NCH), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .timer_ovf_i(timer_ovf_i), .ext_clk_i(ext_clk_i),
        .cap_pin_i(cap_pin_i), .cmp_pin_o(cmp_pin_o), .count_o(count_o),
        .value_o(value_o), .flags_o(flags_o), .ovf_flag_o(ovf_flag_o),
        .cmp_en_o(cmp_en_o), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
    );

    // PWM table: {counter low byte, expected pin} against duty byte 0x40
    localparam logic [8:0] PWM_VEC [8] = '{
        {8'h00, 1'b0}, {8'h3F, 1'b0}, {8'h40, 1'b1}, {8'h41, 1'b1},
        {8'hFF, 1'b1}, {8'h20, 1'b0}, {8'h7F, 1'b1}, {8'h39, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(5'h02, v[7:0]);
        wr(5'h03, v[15:8]);
    endtask

    task automatic pulse();
        timer_ovf_i = 1'b1;
        @(negedge clk);
        timer_ovf_i = 1'b0;
    endtask

    function automatic logic [15:0] val(input int ch);
        return value_o[ch*CW +: CW];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 count", 32'(count_o), 0);
        check("R1 flags", 32'(flags_o), 0);
        check("R1 pins", 32'(cmp_pin_o), 0);
        check("R1 irq/ovf/wdog", {29'd0, irq_o, ovf_flag_o, wdog_rst_o}, 0);
        check("R1 cmp_en", 32'(cmp_en_o), 0);

        // PWM table walk on channel 1 (R6)
        wr(5'h11, 8'h40); wr(5'h19, 8'h40); wr(5'h09, 8'h42);
        for (int k = 0; k < 8; k++) begin
            set_cnt({8'h12, PWM_VEC[k][8:1]});
            idle(2);
            check("R6 pwm level", 32'(cmp_pin_o[1]), 32'(PWM_VEC[k][0]));
        end
        wr(5'h09, 8'h00);
        set_cnt(16'h0000);

        // R2: divide by 4 for 40 clocks, divide by 12 for 36 clocks
        wr(5'h00, 8'h03); idle(39); wr(5'h00, 8'h00);
        check("R2 div4", 32'(count_o), 10);
        set_cnt(16'h0000);
        wr(5'h00, 8'h01); idle(35); wr(5'h00, 8'h00);
        check("R2 div12", 32'(count_o), 3);
        // R2: timer pulses, then halted
        set_cnt(16'h0000);
        wr(5'h00, 8'h05);
        repeat (5) pulse();
        check("R2 timer source", 32'(count_o), 5);
        wr(5'h00, 8'h04); pulse(); idle(1);
        check("R2 halted", 32'(count_o), 5);
        // R2: external pin edges
        wr(5'h00, 8'h07);
        repeat (3) begin ext_clk_i = 1'b1; idle(2); ext_clk_i = 1'b0; idle(2); end
        idle(4);
        check("R2 pin source", 32'(count_o), 8);
        wr(5'h00, 8'h05);

        // R12: counter load
        set_cnt(16'hBEEF);
        check("R12 load", 32'(count_o), 32'h0000BEEF);

        // R7: reload at low-byte wrap
        wr(5'h09, 8'h42); wr(5'h19, 8'h90);
        set_cnt(16'h00FF); pulse();
        check("R7 reload value", 32'(val(1)), 32'h00009090);
        idle(2);
        check("R7 pin after reload", 32'(cmp_pin_o[1]), 0);
        // R8: PWM bit alone does nothing
        wr(5'h09, 8'h02);
        set_cnt(16'h00F0); idle(2);
        check("R8 pin holds", 32'(cmp_pin_o[1]), 0);

        // R5: compare match with toggle on channel 0
        set_cnt(16'h1233);
        wr(5'h10, 8'h34); wr(5'h18, 8'h12); wr(5'h08, 8'h4D);
        pulse();
        check("R5 match flag", 32'(flags_o[0]), 1);
        check("R5 toggle", 32'(cmp_pin_o[0]), 1);
        check("R11 irq enabled flag", 32'(irq_o), 1);
        pulse();
        check("R5 no second toggle", 32'(cmp_pin_o[0]), 1);
        check("R11 flag sticky", 32'(flags_o[0]), 1);
        wr(5'h01, 8'h01);
        check("R11 clear", {30'd0, flags_o[0], irq_o}, 0);

        // R10: half-written compare cannot match
        wr(5'h10, 8'h50);
        check("R10 low clears enable", 32'(cmp_en_o[0]), 0);
        set_cnt(16'h124F); pulse();
        check("R10 no match when disabled", 32'(flags_o[0]), 0);
        wr(5'h18, 8'h12);
        check("R10 high sets enable", 32'(cmp_en_o[0]), 1);
        set_cnt(16'h124F); pulse();
        check("R10 match after high", {30'd0, flags_o[0], cmp_pin_o[0]}, 32'h2);
        wr(5'h01, 8'h01);

        // R4: rising capture on channel 2, falling capture on channel 3
        wr(5'h0A, 8'h20);
        set_cnt(16'h00AB); cap_pin_i[2] = 1'b1; idle(4);
        check("R4 rise capture", {15'd0, flags_o[2], val(2)}, 32'h000100AB);
        set_cnt(16'h0011); cap_pin_i[2] = 1'b0; idle(4);
        check("R4 fall ignored", 32'(val(2)), 32'h00AB);
        wr(5'h0B, 8'h10);
        cap_pin_i[3] = 1'b1; idle(4);
        check("R4 rise ignored", {15'd0, flags_o[3], val(3)}, 0);
        set_cnt(16'h0077); cap_pin_i[3] = 1'b0; idle(4);
        check("R4 fall capture", {15'd0, flags_o[3], val(3)}, 32'h00010077);
        wr(5'h01, 8'h1F);

        // R3: overflow flag and its interrupt
        wr(5'h00, 8'h0D);
        set_cnt(16'hFFFF); pulse();
        check("R3 wrap count", 32'(count_o), 0);
        check("R3 ovf flag and irq", {30'd0, ovf_flag_o, irq_o}, 32'h3);
        wr(5'h01, 8'h80);
        check("R3 ovf clear", {30'd0, ovf_flag_o, irq_o}, 0);

        // R9: watchdog on the last channel
        wr(5'h00, 8'h15);
        wr(5'h14, 8'h10); wr(5'h1C, 8'h00); wr(5'h0C, 8'h4C);
        set_cnt(16'h000F); pulse();
        check("R9 reset pulse", 32'(wdog_rst_o), 1);
        check("R9 pin not toggled", 32'(cmp_pin_o[4]), 0);
        check("R9 flag set", 32'(flags_o[4]), 1);
        idle(1);
        check("R9 pulse one clock", 32'(wdog_rst_o), 0);
        wr(5'h00, 8'h05);
        set_cnt(16'h000F); pulse();
        check("R9 toggle without watchdog", {30'd0, cmp_pin_o[4], wdog_rst_o}, 32'h2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule